// File: doc/BRIEF.md
# Escaped Packet Framer Transmitter

This block turns one outgoing packet into a byte stream for a UART transmitter. A request selects one of two packet kinds. A data packet carries a sequence byte, a payload of one or more bytes and an acknowledgement byte. An ack-only packet carries just the acknowledgement byte. Each packet is framed by its own delimiter byte at both ends. Every byte between the delimiters is escaped, so the delimiter value never shows up inside a frame.

A 16-bit check value is computed over the unescaped body (sequence, payload, acknowledgement). It is appended after the acknowledgement byte and escaped like any other body byte. The payload enters through a valid/ready handshake whose last flag closes the data section. The acknowledgement input is read only when the framer reaches that position, so the packet carries the freshest value. The output is a byte-wide valid/ready stream, and it tolerates back-pressure on any byte.

Top module: `esc_frame_tx`

## Requirements
- R1: After reset `out_valid` and `pay_ready` are low and `req_ready` is high.
- R2: Every packet opens with byte 0xFF and closes with byte 0xFF. Two packets sent back to back produce two adjacent 0xFF bytes, because delimiters are never shared.
- R3: Inside a frame, a byte 0xFF is sent as the pair 0xCB 0x34 and a byte 0xCB is sent as the pair 0xCB 0x00. Any other byte is sent unchanged.
- R4: A data packet body is ordered as follows: the sequence byte, then the payload bytes in arrival order, then the acknowledgement byte, then the check value high byte, then the check value low byte.
- R5: An ack-only packet (`req_data_mode`=0) body is the acknowledgement byte followed by the two check bytes, with no sequence byte and no payload.
- R6: The check value uses polynomial 0x1021, processed MSB first, with start value 0xFFFF and no final inversion. It covers the unescaped sequence, payload and acknowledgement bytes.
- R7: A check byte equal to 0xFF or 0xCB is escaped as in R3.
- R8: The acknowledgement byte sent is the value of `ack_num` at the time the framer reaches the acknowledgement position, not its value when the request was taken.
- R9: While `out_ready` is low, `out_valid` and `out_data` hold. This includes the second byte of an escape pair. No byte is lost or repeated.
- R10: `pay_ready` is high only during the payload section of a data packet. A byte moves when `pay_valid` and `pay_ready` are both high. Accepting a byte with `pay_last` high ends the payload.
- R11: `req_ready` is high only while no packet is in progress. A request is taken when `req_valid` and `req_ready` are both high, and `req_seq` is captured at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Packet request |
| req_ready | output | 1 | Framer idle, request accepted |
| req_data_mode | input | 1 | 1 = data packet, 0 = ack-only packet |
| req_seq | input | 8 | Sequence byte for data packets |
| pay_valid | input | 1 | Payload byte valid |
| pay_ready | output | 1 | Payload byte accepted |
| pay_data | input | 8 | Payload byte |
| pay_last | input | 1 | Marks the final payload byte |
| ack_num | input | 8 | Acknowledgement number, read live |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | UART side ready for a byte |
| out_data | output | 8 | Framed, escaped output byte |

## Verification
The bench builds the framer with its defaults: 8-bit bytes, 0xFF as delimiter, 0xCB as both escape code and remap mask, and the 0x1021 check polynomial starting at 0xFFFF. With these values a search over sequence and acknowledgement bytes finds a packet whose check value contains a reserved byte, which brings the escaping of check bytes within reach. Payloads dense in 0xFF and 0xCB exercise escape pairs in every body position. A pseudo-random `out_ready` pattern then stalls the stream on first and second bytes of those pairs.

// File: rtl/esc_frame_pkg.sv
package esc_frame_pkg;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_OPEN,
        FS_SEQ,
        FS_BODY,
        FS_ACK,
        FS_CHK_HI,
        FS_CHK_LO,
        FS_CLOSE
    } frame_state_e;

endpackage

// File: rtl/efx_crc.sv
module efx_crc #(
    parameter int                BYTE_W = 8,
    parameter int                CRC_W  = 16,
    parameter logic [CRC_W-1:0]  POLY   = 16'h1021,
    parameter logic [CRC_W-1:0]  INIT   = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [BYTE_W-1:0] din,
    output logic [CRC_W-1:0]  crc
);

    typedef struct packed {
        logic [CRC_W-1:0] rem;
    } crc_st_t;

    crc_st_t st_d, st_q;

    // one shift/xor stage per input bit, MSB of the byte first
    logic [CRC_W-1:0] chain [BYTE_W+1];
    assign chain[0] = st_q.rem;

    generate
        for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
            logic fb;
            assign fb = chain[i][CRC_W-1] ^ din[BYTE_W-1-i];
            assign chain[i+1] = {chain[i][CRC_W-2:0], 1'b0} ^ (fb ? POLY : '0);
        end
    endgenerate

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.rem = INIT;
        end else if (en) begin
            st_d.rem = chain[BYTE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rem <= INIT;
        end else begin
            st_q <= st_d;
        end
    end

    assign crc = st_q.rem;

endmodule

// File: rtl/efx_escaper.sv
module efx_escaper #(
    parameter int                BYTE_W   = 8,
    parameter logic [BYTE_W-1:0] DELIM    = 8'hFF,
    parameter logic [BYTE_W-1:0] ESC_CODE = 8'hCB,
    parameter logic [BYTE_W-1:0] ESC_MASK = 8'hCB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sym_valid,
    output logic              sym_ready,
    input  logic [BYTE_W-1:0] sym_data,
    input  logic              sym_body,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data
);

    typedef struct packed {
        logic              ov;
        logic [BYTE_W-1:0] od;
        logic              pv;
        logic [BYTE_W-1:0] pd;
    } esc_st_t;

    esc_st_t st_d, st_q;
    logic    reserved;
    logic    stage_free;

    assign reserved   = sym_body && ((sym_data == DELIM) || (sym_data == ESC_CODE));
    assign stage_free = !st_q.ov || out_ready;
    assign sym_ready  = !st_q.pv && stage_free;

    always_comb begin
        st_d = st_q;
        if (st_q.ov && out_ready) begin
            if (st_q.pv) begin
                st_d.od = st_q.pd;
                st_d.pv = 1'b0;
            end else begin
                st_d.ov = 1'b0;
            end
        end
        if (sym_valid && sym_ready) begin
            st_d.ov = 1'b1;
            if (reserved) begin
                st_d.od = ESC_CODE;
                st_d.pv = 1'b1;
                st_d.pd = sym_data ^ ESC_MASK;
            end else begin
                st_d.od = sym_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.ov;
    assign out_data  = st_q.od;

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    // R3
    esc_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && out_data == ESC_CODE)
        |=> (out_valid && (out_data == (DELIM ^ ESC_MASK) || out_data == (ESC_CODE ^ ESC_MASK))));

    // R2
    no_delim_in_body_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid && sym_ready && sym_body) |=> (out_data != DELIM));

    // R9
    pend_needs_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pv |-> st_q.ov);

endmodule

// File: rtl/efx_ctrl.sv
module efx_ctrl
    import esc_frame_pkg::*;
#(
    parameter int                BYTE_W = 8,
    parameter int                CRC_W  = 16,
    parameter logic [BYTE_W-1:0] DELIM  = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_data_mode,
    input  logic [BYTE_W-1:0] req_seq,
    input  logic              pay_valid,
    output logic              pay_ready,
    input  logic [BYTE_W-1:0] pay_data,
    input  logic              pay_last,
    input  logic [BYTE_W-1:0] ack_num,
    input  logic [CRC_W-1:0]  crc_val,
    output logic              crc_clr,
    output logic              crc_en,
    output logic              sym_valid,
    input  logic              sym_ready,
    output logic [BYTE_W-1:0] sym_data,
    output logic              sym_body
);

    typedef struct packed {
        frame_state_e      state;
        logic              data_mode;
        logic [BYTE_W-1:0] seq;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    logic     fire;

    assign fire = sym_valid && sym_ready;

    always_comb begin
        st_d      = st_q;
        req_ready = 1'b0;
        pay_ready = 1'b0;
        sym_valid = 1'b0;
        sym_data  = '0;
        sym_body  = 1'b0;
        crc_clr   = 1'b0;
        crc_en    = 1'b0;
        unique case (st_q.state)
            FS_IDLE: begin
                req_ready = 1'b1;
                if (req_valid) begin
                    crc_clr         = 1'b1;
                    st_d.data_mode  = req_data_mode;
                    st_d.seq        = req_seq;
                    st_d.state      = FS_OPEN;
                end
            end
            FS_OPEN: begin
                sym_valid = 1'b1;
                sym_data  = DELIM;
                if (fire) st_d.state = st_q.data_mode ? FS_SEQ : FS_ACK;
            end
            FS_SEQ: begin
                sym_valid = 1'b1;
                sym_body  = 1'b1;
                sym_data  = st_q.seq;
                crc_en    = fire;
                if (fire) st_d.state = FS_BODY;
            end
            FS_BODY: begin
                sym_valid = pay_valid;
                sym_body  = 1'b1;
                sym_data  = pay_data;
                pay_ready = sym_ready;
                crc_en    = fire;
                if (fire && pay_last) st_d.state = FS_ACK;
            end
            FS_ACK: begin
                sym_valid = 1'b1;
                sym_body  = 1'b1;
                sym_data  = ack_num;
                crc_en    = fire;
                if (fire) st_d.state = FS_CHK_HI;
            end
            FS_CHK_HI: begin
                sym_valid = 1'b1;
                sym_body  = 1'b1;
                sym_data  = crc_val[CRC_W-1 -: BYTE_W];
                if (fire) st_d.state = FS_CHK_LO;
            end
            FS_CHK_LO: begin
                sym_valid = 1'b1;
                sym_body  = 1'b1;
                sym_data  = crc_val[BYTE_W-1:0];
                if (fire) st_d.state = FS_CLOSE;
            end
            FS_CLOSE: begin
                sym_valid = 1'b1;
                sym_data  = DELIM;
                if (fire) st_d.state = FS_IDLE;
            end
            default: st_d.state = FS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state     <= FS_IDLE;
            st_q.data_mode <= 1'b0;
            st_q.seq       <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R11
    busy_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10
    last_ends_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pay_valid && pay_ready && pay_last) |=> !pay_ready);

    // R10
    pay_excl_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pay_ready && req_ready));

endmodule

// File: rtl/esc_frame_tx.sv
module esc_frame_tx #(
    parameter int                BYTE_W   = 8,
    parameter logic [BYTE_W-1:0] DELIM    = 8'hFF,
    parameter logic [BYTE_W-1:0] ESC_CODE = 8'hCB,
    parameter logic [BYTE_W-1:0] ESC_MASK = 8'hCB,
    parameter logic [15:0]       CRC_POLY = 16'h1021,
    parameter logic [15:0]       CRC_INIT = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_data_mode,
    input  logic [BYTE_W-1:0] req_seq,
    input  logic              pay_valid,
    output logic              pay_ready,
    input  logic [BYTE_W-1:0] pay_data,
    input  logic              pay_last,
    input  logic [BYTE_W-1:0] ack_num,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BYTE_W-1:0] out_data
);

    localparam int CRC_W = 2 * BYTE_W;

    logic              sym_valid;
    logic              sym_ready;
    logic [BYTE_W-1:0] sym_data;
    logic              sym_body;
    logic              crc_clr;
    logic              crc_en;
    logic [CRC_W-1:0]  crc_val;

    efx_ctrl #(
        .BYTE_W (BYTE_W),
        .CRC_W  (CRC_W),
        .DELIM  (DELIM)
    ) ctrl_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_data_mode (req_data_mode),
        .req_seq       (req_seq),
        .pay_valid     (pay_valid),
        .pay_ready     (pay_ready),
        .pay_data      (pay_data),
        .pay_last      (pay_last),
        .ack_num       (ack_num),
        .crc_val       (crc_val),
        .crc_clr       (crc_clr),
        .crc_en        (crc_en),
        .sym_valid     (sym_valid),
        .sym_ready     (sym_ready),
        .sym_data      (sym_data),
        .sym_body      (sym_body)
    );

    efx_crc #(
        .BYTE_W (BYTE_W),
        .CRC_W  (CRC_W),
        .POLY   (CRC_W'(CRC_POLY)),
        .INIT   (CRC_W'(CRC_INIT))
    ) crc_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (crc_clr),
        .en    (crc_en),
        .din   (sym_data),
        .crc   (crc_val)
    );

    efx_escaper #(
        .BYTE_W   (BYTE_W),
        .DELIM    (DELIM),
        .ESC_CODE (ESC_CODE),
        .ESC_MASK (ESC_MASK)
    ) esc_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_valid (sym_valid),
        .sym_ready (sym_ready),
        .sym_data  (sym_data),
        .sym_body  (sym_body),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

    // R5
    no_pay_in_ack_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_data_mode) |=> !pay_ready);

endmodule

// File: tb/esc_frame_tx_tb_top.sv
module esc_frame_tx_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic       req_ready;
    logic       req_data_mode = 1'b0;
    logic [7:0] req_seq = '0;
    logic       pay_valid = 1'b0;
    logic       pay_ready;
    logic [7:0] pay_data = '0;
    logic       pay_last = 1'b0;
    logic [7:0] ack_num = '0;
    logic       out_valid;
    logic       out_ready;
    logic [7:0] out_data;

    always #10 clk = ~clk;

    esc_frame_tx dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_data_mode(req_data_mode), .req_seq(req_seq),
        .pay_valid(pay_valid), .pay_ready(pay_ready),
        .pay_data(pay_data), .pay_last(pay_last),
        .ack_num(ack_num),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    int         n_checks = 0;
    int         n_fails  = 0;
    logic [7:0] cap[$];
    logic [7:0] exp_q[$];
    logic [7:0] pay_q[$];
    bit         stall_mode = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    bit         late_ack = 1'b0;
    logic [7:0] late_ack_val = '0;
    int         hold_viol = 0;
    int         hold_seen = 0;
    int         pay_rdy_seen = 0;
    bit         prev_stall = 1'b0;
    logic [7:0] prev_data = '0;

    // output ready driver, changes just after the edge
    initial out_ready = 1'b1;
    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = stall_mode ? (lfsr[0] & lfsr[3]) : 1'b1;
    end

    // monitor between edges
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                hold_seen++;
                if (!out_valid || out_data != prev_data) hold_viol++;
            end
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            if (out_valid && out_ready) cap.push_back(out_data);
            if (pay_ready) pay_rdy_seen++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [15:0] crc_upd(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {b, 8'h00};
        for (int k = 0; k < 8; k++) r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
        return r;
    endfunction

    task automatic push_body(input logic [7:0] b);
        if (b == 8'hFF) begin exp_q.push_back(8'hCB); exp_q.push_back(8'h34); end
        else if (b == 8'hCB) begin exp_q.push_back(8'hCB); exp_q.push_back(8'h00); end
        else exp_q.push_back(b);
    endtask

    function automatic logic [15:0] pkt_crc(input bit mode, input logic [7:0] seq,
                                            input logic [7:0] ack);
        logic [15:0] c = 16'hFFFF;
        if (mode) begin
            c = crc_upd(c, seq);
            foreach (pay_q[i]) c = crc_upd(c, pay_q[i]);
        end
        return crc_upd(c, ack);
    endfunction

    // appends one expected packet to exp_q
    task automatic build_exp(input bit mode, input logic [7:0] seq, input logic [7:0] ack);
        logic [15:0] c;
        c = pkt_crc(mode, seq, ack);
        exp_q.push_back(8'hFF);
        if (mode) begin
            push_body(seq);
            foreach (pay_q[i]) push_body(pay_q[i]);
        end
        push_body(ack);
        push_body(c[15:8]);
        push_body(c[7:0]);
        exp_q.push_back(8'hFF);
    endtask

    task automatic send_req(input bit mode, input logic [7:0] seq);
        @(posedge clk); #2;
        req_valid = 1'b1; req_data_mode = mode; req_seq = seq;
        do @(negedge clk); while (!req_ready);
        @(posedge clk); #2;
        req_valid = 1'b0; req_seq = 8'h5C;
    endtask

    task automatic send_pay();
        foreach (pay_q[i]) begin
            pay_valid = 1'b1; pay_data = pay_q[i]; pay_last = (i == pay_q.size() - 1);
            do @(negedge clk); while (!pay_ready);
            @(posedge clk); #2;
            if (late_ack && i == 0) ack_num = late_ack_val;
        end
        pay_valid = 1'b0; pay_last = 1'b0;
    endtask

    task automatic wait_and_compare(input string req);
        int first_bad = -1;
        while (cap.size() < exp_q.size()) @(negedge clk);
        repeat (6) @(negedge clk);
        chk(cap.size() == exp_q.size(), req, "byte count", cap.size(), exp_q.size());
        foreach (exp_q[i])
            if (first_bad < 0 && (i >= cap.size() || cap[i] != exp_q[i])) first_bad = i;
        if (first_bad >= 0)
            chk(1'b0, req, $sformatf("byte %0d", first_bad),
                (first_bad < cap.size()) ? int'(cap[first_bad]) : -1, exp_q[first_bad]);
        else
            chk(1'b1, req, "stream", 0, 0);
    endtask

    task automatic run_packet(input string req, input bit mode, input logic [7:0] seq,
                              input logic [7:0] ack);
        cap.delete(); exp_q.delete();
        ack_num = ack;
        build_exp(mode, seq, late_ack ? late_ack_val : ack);
        send_req(mode, seq);
        if (mode) send_pay();
        wait_and_compare(req);
    endtask

    task automatic t_reset();
        chk(out_valid == 1'b0, "R1", "out_valid", out_valid, 0);
        chk(req_ready == 1'b1, "R1", "req_ready", req_ready, 1);
        chk(pay_ready == 1'b0, "R1", "pay_ready", pay_ready, 0);
    endtask

    task automatic t_ack_only();
        pay_q.delete();
        pay_rdy_seen = 0;
        pay_valid = 1'b1; pay_data = 8'h77; pay_last = 1'b1;  // must be ignored
        run_packet("R5", 1'b0, 8'h00, 8'h42);
        chk(pay_rdy_seen == 0, "R10", "pay_ready in ack-only", pay_rdy_seen, 0);
        pay_valid = 1'b0; pay_last = 1'b0;
    endtask

    task automatic t_data_plain();
        pay_q = '{8'h68, 8'h69, 8'h0A};
        run_packet("R4", 1'b1, 8'h01, 8'h07);
        chk(exp_q.size() > 3 && cap.size() > 3 && cap[0] == 8'hFF && cap[1] == 8'h01,
            "R4", "seq first", cap.size() > 1 ? int'(cap[1]) : -1, 1);
        pay_q = '{8'h00};
        run_packet("R6", 1'b1, 8'h80, 8'h00);
    endtask

    task automatic t_escapes();
        pay_q = '{8'hCB, 8'hFF, 8'h34, 8'h00, 8'hFF, 8'hFF};
        run_packet("R3", 1'b1, 8'hFF, 8'hCB);
    endtask

    task automatic t_crc_escape();
        bit found = 1'b0;
        logic [7:0] fs = '0, fa = '0;
        logic [15:0] c;
        pay_q = '{8'h00};
        for (int s = 0; s < 256 && !found; s++)
            for (int a = 0; a < 256 && !found; a++) begin
                c = pkt_crc(1'b1, 8'(s), 8'(a));
                if (c[15:8] == 8'hFF || c[15:8] == 8'hCB || c[7:0] == 8'hFF || c[7:0] == 8'hCB) begin
                    found = 1'b1; fs = 8'(s); fa = 8'(a);
                end
            end
        chk(found, "R7", "reserved check byte found", found, 1);
        run_packet("R7", 1'b1, fs, fa);
    endtask

    task automatic t_late_ack();
        pay_q = '{8'h10, 8'h20, 8'h30, 8'h40};
        late_ack = 1'b1; late_ack_val = 8'h5A;
        run_packet("R8", 1'b1, 8'h02, 8'h11);
        late_ack = 1'b0;
    endtask

    task automatic t_stall();
        hold_seen = 0; hold_viol = 0;
        stall_mode = 1'b1;
        pay_q = '{8'hFF, 8'hCB, 8'hFF, 8'h12, 8'hCB, 8'hCB, 8'h99};
        run_packet("R9", 1'b1, 8'hCB, 8'hFF);
        pay_q = '{};
        run_packet("R9", 1'b0, 8'h00, 8'hFF);
        stall_mode = 1'b0;
        chk(hold_viol == 0, "R9", "hold violations", hold_viol, 0);
        chk(hold_seen > 0, "R9", "stall cycles seen", hold_seen > 0, 1);
    endtask

    task automatic t_back_to_back();
        int n1;
        cap.delete(); exp_q.delete(); pay_q.delete();
        ack_num = 8'h21;
        build_exp(1'b0, 8'h00, 8'h21);
        n1 = exp_q.size();
        build_exp(1'b0, 8'h00, 8'h21);
        send_req(1'b0, 8'h00);
        @(negedge clk);
        chk(req_ready == 1'b0, "R11", "req_ready while busy", req_ready, 0);
        send_req(1'b0, 8'h00);
        wait_and_compare("R2");
        chk(cap.size() > n1 && cap[n1-1] == 8'hFF && cap[n1] == 8'hFF, "R2", "FF FF between packets",
            cap.size() > n1 ? int'(cap[n1]) : -1, 8'hFF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ack_only();
        t_data_plain();
        t_escapes();
        t_crc_escape();
        t_late_ack();
        t_stall();
        t_back_to_back();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule